// File: doc/BRIEF.md
# Prioritized Interrupt Stacking Sequencer

This block handles the stack traffic that a small 8-bit CPU core needs when it enters an interrupt and when it returns from one. It chooses one request from four sources: the post-reset start, a software interrupt command, an external interrupt line and a timer request. For an interrupt entry it writes the CPU state to a stack one byte per cycle. It then reads a two-byte vector and hands back the new program counter, with the interrupt mask set in the condition code. A return-from-interrupt command reads the saved state back in the opposite order.

The block also serves subroutine calls and returns, which move the program counter only. A command that resets the stack pointer is handled too. The stack lives in a 32-byte window at $060-$07F. The stack pointer keeps only its low five bits and wraps inside that window. The core gives its register values and the mask bit as inputs. It loads the restored registers when `done_o` pulses. Memory is a byte bus whose read data is valid in the same cycle.

Top module: `irq_stack_seq`

## Requirements
- R1: While reset is applied and afterwards, `sp_o` starts at $07F. After reset is released, the block reads only $7FE and then $7FF, writes nothing, and finishes with `pc_o` taken from that vector and the mask bit (`cc_o[3]`) at 1.
- R2: When several sources are pending at an idle cycle, the order of service is start-up, then software interrupt, then external, then timer. The vector pairs are $7FC/$7FD for software, $7FA/$7FB for external and $7F8/$7F9 for timer.
- R3: An interrupt entry makes five writes at the current stack address, and the pointer drops by one after each write. The bytes go out as PC[7:0] first, then {5'b11111, PC[10:8]}, then X, then A, then {3'b111, CC}.
- R4: In a vector pair, the even address is read first and its bits [2:0] become PC[10:8]. The odd address is read next and gives PC[7:0].
- R5: An entry returns `cc_o` equal to the input CC with bit 3 (the mask; CC bit order is H, I, N, Z, C from bit 4 down) set, and `a_o`/`x_o` equal to the inputs. External and timer requests are not taken while `cc_i[3]` is 1. A latched external request is served once `cc_i[3]` goes to 0. The software interrupt is taken whatever the mask.
- R6: The external request is latched on a falling edge of `ext_irq_ni`. The latch clears when its vector fetch starts. A line that stays low raises no second request.
- R7: Return-from-interrupt makes five reads. The pointer rises by one before each read. The bytes restore CC from bits [4:0], then A, then X, then PC[10:8], then PC[7:0].
- R8: A subroutine call writes PC[7:0] and then {5'b11111, PC[10:8]}. A subroutine return reads the high byte and then the low byte, and rebuilds `pc_o`.
- R9: Every stack access falls in $060-$07F. The pointer wraps from $060 to $07F on a push, and the other way on a pull.
- R10: The stack-pointer reset command sets `sp_o` to $07F and makes no bus access.
- R11: Commands (`swi_i`, `rti_i`, `rts_i`, `jsr_i`, `rsp_i`) are sampled only when `busy_o` is 0 and are ignored otherwise. `done_o` is a one-cycle pulse in the cycle after the last bus access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| swi_i | input | 1 | Software interrupt command |
| ext_irq_ni | input | 1 | External interrupt line, active low, edge-latched |
| tmr_req_i | input | 1 | Timer interrupt request level |
| rti_i | input | 1 | Return-from-interrupt command |
| rts_i | input | 1 | Subroutine return command |
| jsr_i | input | 1 | Subroutine call command |
| rsp_i | input | 1 | Stack pointer reset command |
| pc_i | input | 11 | Current program counter |
| a_i | input | 8 | Current accumulator |
| x_i | input | 8 | Current index register |
| cc_i | input | 5 | Current condition code, bit 3 is the mask |
| mem_addr_o | output | 11 | Memory address |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read strobe |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, same cycle |
| pc_o | output | 11 | Program counter to load |
| a_o | output | 8 | Accumulator to load |
| x_o | output | 8 | Index register to load |
| cc_o | output | 5 | Condition code to load |
| sp_o | output | 11 | Stack pointer |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished, outputs valid |

## Verification
The key overlaps are a software interrupt command arriving in the same idle cycle as a latched external edge and a raised timer request, and an external edge that meets a cleared mask while the timer is also asking. The bench holds the mask set, drops the external line and raises the timer, then pulses the software command. It then clears the mask with both others still pending. It judges each step by which vector pair appears on the bus and by the full write sequence, compared with a bench model of the stack. A command held during a busy sequence is also checked: after `done_o` it must leave the bus and the pointer untouched.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  // source code doubles as the vector pair index: base + 2*src
  typedef enum logic [1:0] {
    SRC_TMR = 2'd0,
    SRC_EXT = 2'd1,
    SRC_SWI = 2'd2,
    SRC_RST = 2'd3
  } src_e;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_INT  = 3'd1,
    OP_RST  = 3'd2,
    OP_RTI  = 3'd3,
    OP_JSR  = 3'd4,
    OP_RTS  = 3'd5
  } op_e;

  localparam logic [2:0] STEP_VEC_HI = 3'd5;
  localparam logic [2:0] STEP_VEC_LO = 3'd6;

endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic swi_i,
  input  logic ext_irq_ni,
  input  logic tmr_req_i,
  input  logic mask_i,
  input  logic take_i,
  input  logic clr_ext_i,
  output logic req_valid_o,
  output src_e req_src_o
);

  logic ext_prev_q, ext_pend_q, rst_pend_q;
  logic ext_fall;

  assign ext_fall = ext_prev_q & ~ext_irq_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_prev_q <= 1'b1;
      ext_pend_q <= 1'b0;
      rst_pend_q <= 1'b1;
    end else begin
      ext_prev_q <= ext_irq_ni;
      // a new edge wins over a clear in the same cycle
      ext_pend_q <= ext_fall | (ext_pend_q & ~clr_ext_i);
      if (take_i && req_src_o == SRC_RST) rst_pend_q <= 1'b0;
    end
  end

  always_comb begin
    req_valid_o = 1'b1;
    req_src_o   = SRC_TMR;
    if (rst_pend_q)                  req_src_o = SRC_RST;
    else if (swi_i)                  req_src_o = SRC_SWI;
    else if (ext_pend_q && !mask_i)  req_src_o = SRC_EXT;
    else if (tmr_req_i && !mask_i)   req_src_o = SRC_TMR;
    else                             req_valid_o = 1'b0;
  end

endmodule

// File: rtl/irq_sp.sv
module irq_sp #(
  parameter int                ADDR_W  = 11,
  parameter int                SP_W    = 5,
  parameter logic [ADDR_W-1:0] SP_BASE = 11'h060
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sp_rst_i,
  input  logic              push_i,
  input  logic              pull_i,
  output logic [ADDR_W-1:0] sp_addr_o,
  output logic [ADDR_W-1:0] pull_addr_o
);

  logic [SP_W-1:0] sp_q, sp_inc;

  assign sp_inc      = sp_q + 1'b1;
  assign sp_addr_o   = SP_BASE | ADDR_W'(sp_q);
  assign pull_addr_o = SP_BASE | ADDR_W'(sp_inc);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sp_q <= '1;
    else if (sp_rst_i) sp_q <= '1;
    else if (push_i)   sp_q <= sp_q - 1'b1;
    else if (pull_i)   sp_q <= sp_inc;
  end

endmodule

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter int CC_W   = 5,
  parameter int I_BIT  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  src_e              req_src_i,
  input  logic              rti_i,
  input  logic              rts_i,
  input  logic              jsr_i,
  input  logic              rsp_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic [CC_W-1:0]   cc_i,
  input  logic [ADDR_W-1:0] sp_addr_i,
  input  logic [ADDR_W-1:0] pull_addr_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              take_o,
  output logic              clr_ext_o,
  output logic              push_o,
  output logic              pull_o,
  output logic              sp_rst_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] a_o,
  output logic [DATA_W-1:0] x_o,
  output logic [CC_W-1:0]   cc_o,
  output logic              busy_o,
  output logic              done_o
);

  localparam int HI_W   = ADDR_W - DATA_W;
  localparam int PAD_PC = DATA_W - HI_W;
  localparam int PAD_CC = DATA_W - CC_W;
  localparam logic [ADDR_W-1:0] VEC_BASE = {{(ADDR_W-3){1'b1}}, 3'b000};
  localparam logic [CC_W-1:0]   I_MASK   = CC_W'(1) << I_BIT;

  logic              busy_q, done_q;
  op_e               op_q;
  src_e              src_q;
  logic [2:0]        step_q;
  logic [ADDR_W-1:0] pc_q, pc_r;
  logic [DATA_W-1:0] a_q, x_q, a_r, x_r;
  logic [CC_W-1:0]   cc_q, cc_r;

  logic start_int, start_rti, start_rts, start_jsr, start_rsp;
  logic push_ph, pull_ph, vec_ph, last;
  logic [ADDR_W-1:0] vec_addr;

  always_comb begin
    start_int = !busy_q && req_valid_i;
    start_rti = !busy_q && !req_valid_i && rti_i;
    start_rts = !busy_q && !req_valid_i && !rti_i && rts_i;
    start_jsr = !busy_q && !req_valid_i && !rti_i && !rts_i && jsr_i;
    start_rsp = !busy_q && !req_valid_i && !rti_i && !rts_i && !jsr_i && rsp_i;
  end

  assign push_ph  = busy_q && ((op_q == OP_INT && step_q < STEP_VEC_HI) || op_q == OP_JSR);
  assign pull_ph  = busy_q && (op_q == OP_RTI || op_q == OP_RTS);
  assign vec_ph   = busy_q && (op_q == OP_INT || op_q == OP_RST) && step_q >= STEP_VEC_HI;
  assign vec_addr = VEC_BASE | ADDR_W'({src_q, step_q == STEP_VEC_LO});

  always_comb begin
    case (op_q)
      OP_INT, OP_RST: last = (step_q == STEP_VEC_LO);
      OP_RTI:         last = (step_q == 3'd4);
      OP_JSR, OP_RTS: last = (step_q == 3'd1);
      default:        last = 1'b1;
    endcase
  end

  always_comb begin
    case (step_q)
      3'd0:    mem_wdata_o = pc_q[DATA_W-1:0];
      3'd1:    mem_wdata_o = {{PAD_PC{1'b1}}, pc_q[ADDR_W-1:DATA_W]};
      3'd2:    mem_wdata_o = x_q;
      3'd3:    mem_wdata_o = a_q;
      default: mem_wdata_o = {{PAD_CC{1'b1}}, cc_q};
    endcase
  end

  always_comb begin
    if (push_ph)      mem_addr_o = sp_addr_i;
    else if (pull_ph) mem_addr_o = pull_addr_i;
    else if (vec_ph)  mem_addr_o = vec_addr;
    else              mem_addr_o = '0;
  end

  assign mem_we_o  = push_ph;
  assign mem_re_o  = pull_ph | vec_ph;
  assign push_o    = push_ph;
  assign pull_o    = pull_ph;
  assign sp_rst_o  = start_rsp;
  assign take_o    = start_int;
  assign clr_ext_o = vec_ph && src_q == SRC_EXT && step_q == STEP_VEC_HI;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      op_q   <= OP_NONE;
      src_q  <= SRC_TMR;
      step_q <= '0;
      pc_q   <= '0;
      a_q    <= '0;
      x_q    <= '0;
      cc_q   <= '0;
      pc_r   <= '0;
      a_r    <= '0;
      x_r    <= '0;
      cc_r   <= I_MASK;
    end else begin
      done_q <= 1'b0;
      if (start_int) begin
        busy_q <= 1'b1;
        src_q  <= req_src_i;
        pc_q   <= pc_i;
        a_q    <= a_i;
        x_q    <= x_i;
        cc_q   <= cc_i;
        if (req_src_i == SRC_RST) begin
          op_q   <= OP_RST;
          step_q <= STEP_VEC_HI;
          cc_r   <= cc_r | I_MASK;
        end else begin
          op_q   <= OP_INT;
          step_q <= '0;
          a_r    <= a_i;
          x_r    <= x_i;
          cc_r   <= cc_i | I_MASK;
        end
      end else if (start_rti || start_rts || start_jsr) begin
        busy_q <= 1'b1;
        step_q <= '0;
        pc_q   <= pc_i;
        op_q   <= start_rti ? OP_RTI : (start_rts ? OP_RTS : OP_JSR);
      end else if (start_rsp) begin
        done_q <= 1'b1;
      end else if (busy_q) begin
        step_q <= step_q + 1'b1;
        if (op_q == OP_RTI) begin
          case (step_q)
            3'd0:    cc_r <= mem_rdata_i[CC_W-1:0];
            3'd1:    a_r  <= mem_rdata_i;
            3'd2:    x_r  <= mem_rdata_i;
            3'd3:    pc_r[ADDR_W-1:DATA_W] <= mem_rdata_i[HI_W-1:0];
            default: pc_r[DATA_W-1:0] <= mem_rdata_i;
          endcase
        end else if (op_q == OP_RTS || vec_ph) begin
          if (step_q == 3'd0 || step_q == STEP_VEC_HI)
            pc_r[ADDR_W-1:DATA_W] <= mem_rdata_i[HI_W-1:0];
          else
            pc_r[DATA_W-1:0] <= mem_rdata_i;
        end
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          op_q   <= OP_NONE;
        end
      end
    end
  end

  assign pc_o   = pc_r;
  assign a_o    = a_r;
  assign x_o    = x_r;
  assign cc_o   = cc_r;
  assign busy_o = busy_q;
  assign done_o = done_q;

endmodule

// File: rtl/irq_stack_seq.sv
module irq_stack_seq
  import irq_seq_pkg::*;
#(
  parameter int                ADDR_W  = 11,
  parameter int                DATA_W  = 8,
  parameter int                CC_W    = 5,
  parameter int                SP_W    = 5,
  parameter int                I_BIT   = 3,
  parameter logic [ADDR_W-1:0] SP_BASE = 11'h060
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              swi_i,
  input  logic              ext_irq_ni,
  input  logic              tmr_req_i,
  input  logic              rti_i,
  input  logic              rts_i,
  input  logic              jsr_i,
  input  logic              rsp_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic [CC_W-1:0]   cc_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] a_o,
  output logic [DATA_W-1:0] x_o,
  output logic [CC_W-1:0]   cc_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic              busy_o,
  output logic              done_o
);

  logic              req_valid, take, clr_ext, push, pull, sp_rst;
  src_e              req_src;
  logic [ADDR_W-1:0] pull_addr;

  irq_arbiter u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .swi_i       (swi_i),
    .ext_irq_ni  (ext_irq_ni),
    .tmr_req_i   (tmr_req_i),
    .mask_i      (cc_i[I_BIT]),
    .take_i      (take),
    .clr_ext_i   (clr_ext),
    .req_valid_o (req_valid),
    .req_src_o   (req_src)
  );

  irq_sp #(
    .ADDR_W  (ADDR_W),
    .SP_W    (SP_W),
    .SP_BASE (SP_BASE)
  ) u_sp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sp_rst_i    (sp_rst),
    .push_i      (push),
    .pull_i      (pull),
    .sp_addr_o   (sp_o),
    .pull_addr_o (pull_addr)
  );

  irq_seq_ctrl #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CC_W   (CC_W),
    .I_BIT  (I_BIT)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid),
    .req_src_i   (req_src),
    .rti_i       (rti_i),
    .rts_i       (rts_i),
    .jsr_i       (jsr_i),
    .rsp_i       (rsp_i),
    .pc_i        (pc_i),
    .a_i         (a_i),
    .x_i         (x_i),
    .cc_i        (cc_i),
    .sp_addr_i   (sp_o),
    .pull_addr_i (pull_addr),
    .mem_rdata_i (mem_rdata_i),
    .take_o      (take),
    .clr_ext_o   (clr_ext),
    .push_o      (push),
    .pull_o      (pull),
    .sp_rst_o    (sp_rst),
    .mem_addr_o  (mem_addr_o),
    .mem_we_o    (mem_we_o),
    .mem_re_o    (mem_re_o),
    .mem_wdata_o (mem_wdata_o),
    .pc_o        (pc_o),
    .a_o         (a_o),
    .x_o         (x_o),
    .cc_o        (cc_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

endmodule

// File: rtl/irq_stack_seq_chk.sv
module irq_stack_seq_chk #(
  parameter int                ADDR_W  = 11,
  parameter int                SP_W    = 5,
  parameter logic [ADDR_W-1:0] SP_BASE = 11'h060
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_we_o,
  input logic              mem_re_o,
  input logic [ADDR_W-1:0] sp_o,
  input logic              busy_o,
  input logic              done_o
);

  localparam logic [ADDR_W-1:0] WIN_MASK = ADDR_W'((1 << SP_W) - 1);
  localparam logic [ADDR_W-1:0] VEC_BASE = {{(ADDR_W-3){1'b1}}, 3'b000};

  logic in_win, vec_even;
  assign in_win   = (mem_addr_o & ~WIN_MASK) == SP_BASE;
  assign vec_even = (mem_addr_o & ~ADDR_W'(7)) == VEC_BASE && !mem_addr_o[0];

  // R9
  stack_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> in_win);

  // R3
  push_sp_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> sp_o[SP_W-1:0] == SP_W'($past(sp_o[SP_W-1:0]) - 1'b1));

  // R7
  pull_preinc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_re_o && in_win) |=> sp_o == $past(mem_addr_o));

  // R4
  vec_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_re_o && vec_even) |=> (mem_re_o && mem_addr_o == $past(mem_addr_o) + 1'b1));

  // R11
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R11
  bus_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(mem_we_o || mem_re_o));

endmodule

bind irq_stack_seq irq_stack_seq_chk #(
  .ADDR_W  (ADDR_W),
  .SP_W    (SP_W),
  .SP_BASE (SP_BASE)
) u_chk (.*);

// File: tb/irq_stack_seq_test.sv
module irq_stack_seq_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic swi = 0, ext_n = 1, tmr = 0, rti = 0, rts = 0, jsr = 0, rsp = 0;
  logic [10:0] pc_in = '0;
  logic [7:0]  a_in = '0, x_in = '0;
  logic [4:0]  cc_in = 5'b01000;
  logic [10:0] mem_addr, pc_o, sp_o;
  logic        mem_we, mem_re, busy, done;
  logic [7:0]  mem_wdata, mem_rdata, a_o, x_o;
  logic [4:0]  cc_o;

  always #5 clk = ~clk;

  irq_stack_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .swi_i(swi), .ext_irq_ni(ext_n), .tmr_req_i(tmr),
    .rti_i(rti), .rts_i(rts), .jsr_i(jsr), .rsp_i(rsp),
    .pc_i(pc_in), .a_i(a_in), .x_i(x_in), .cc_i(cc_in),
    .mem_addr_o(mem_addr), .mem_we_o(mem_we), .mem_re_o(mem_re),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .pc_o(pc_o), .a_o(a_o), .x_o(x_o), .cc_o(cc_o), .sp_o(sp_o),
    .busy_o(busy), .done_o(done)
  );

  logic [7:0] mem [0:2047];
  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bus logger
  logic        l_we   [0:63];
  logic [10:0] l_addr [0:63];
  logic [7:0]  l_data [0:63];
  int n_log = 0;
  always @(negedge clk) if ((mem_we || mem_re) && n_log < 64) begin
    l_we[n_log]   = mem_we;
    l_addr[n_log] = mem_addr;
    l_data[n_log] = mem_we ? mem_wdata : mem_rdata;
    n_log++;
  end

  // expected model
  logic        e_we   [0:63];
  logic [10:0] e_addr [0:63];
  logic [7:0]  e_data [0:63];
  int n_exp = 0;
  logic [4:0]  bsp = 5'h1F;
  logic [7:0]  sh [0:31];
  logic [10:0] e_pc;
  logic [7:0]  e_a, e_x;
  logic [4:0]  e_cc;

  function automatic logic [7:0] vec_byte(input logic [10:0] ad);
    case (ad[2:0])
      3'd0: return 8'hF5; 3'd1: return 8'hA0;
      3'd2: return 8'h03; 3'd3: return 8'h11;
      3'd4: return 8'hFE; 3'd5: return 8'h42;
      3'd6: return 8'h07; default: return 8'h00;
    endcase
  endfunction

  function automatic logic [10:0] stk(input logic [4:0] p);
    return {6'b000011, p};
  endfunction

  task automatic exp_push(input logic [7:0] d);
    e_we[n_exp] = 1; e_addr[n_exp] = stk(bsp); e_data[n_exp] = d;
    sh[bsp] = d; bsp = bsp - 5'd1; n_exp++;
  endtask

  task automatic exp_pull(output logic [7:0] d);
    bsp = bsp + 5'd1; d = sh[bsp];
    e_we[n_exp] = 0; e_addr[n_exp] = stk(bsp); e_data[n_exp] = d; n_exp++;
  endtask

  task automatic exp_vec(input int s);
    logic [10:0] ad;
    ad = 11'h7F8 + 11'(2*s);
    e_we[n_exp] = 0; e_addr[n_exp] = ad;     e_data[n_exp] = vec_byte(ad);     n_exp++;
    e_we[n_exp] = 0; e_addr[n_exp] = ad + 1; e_data[n_exp] = vec_byte(ad + 1); n_exp++;
    e_pc = {vec_byte(ad)[2:0], vec_byte(ad + 1)};
  endtask

  task automatic prep_int(input int s);
    n_exp = 0;
    exp_push(pc_in[7:0]);
    exp_push({5'b11111, pc_in[10:8]});
    exp_push(x_in);
    exp_push(a_in);
    exp_push({3'b111, cc_in});
    exp_vec(s);
    e_a = a_in; e_x = x_in; e_cc = cc_in | 5'b01000;
  endtask

  task automatic prep_rti();
    logic [7:0] b0, b1, b2, b3, b4;
    n_exp = 0;
    exp_pull(b0); exp_pull(b1); exp_pull(b2); exp_pull(b3); exp_pull(b4);
    e_cc = b0[4:0]; e_a = b1; e_x = b2; e_pc = {b3[2:0], b4};
  endtask

  task automatic prep_jsr();
    n_exp = 0;
    exp_push(pc_in[7:0]);
    exp_push({5'b11111, pc_in[10:8]});
  endtask

  task automatic prep_rts();
    logic [7:0] hi, lo;
    n_exp = 0;
    exp_pull(hi); exp_pull(lo);
    e_pc = {hi[2:0], lo};
  endtask

  // caller stands at a negedge
  task automatic issue(input int c);
    n_log = 0;
    case (c)
      0: swi = 1; 1: rti = 1; 2: rts = 1; 3: jsr = 1; default: rsp = 1;
    endcase
    @(posedge clk); @(negedge clk);
    swi = 0; rti = 0; rts = 0; jsr = 0; rsp = 0;
  endtask

  task automatic wait_done(input string tag);
    for (int i = 0; i < 40 && !done; i++) @(negedge clk);
    chk(done, {tag, " done pulse"}, done, 1);
  endtask

  // mode: 0 bus+sp, 1 +pc, 2 all regs
  task automatic judge(input string tag, input int mode);
    chk(n_log == n_exp, {tag, " bus count"}, n_log, n_exp);
    for (int i = 0; i < n_exp && i < n_log; i++)
      chk(l_we[i] == e_we[i] && l_addr[i] == e_addr[i] && l_data[i] == e_data[i],
          {tag, " bus op"}, {l_we[i], l_addr[i], l_data[i]}, {e_we[i], e_addr[i], e_data[i]});
    chk(sp_o == stk(bsp), {tag, " sp"}, sp_o, stk(bsp));
    if (mode >= 1) chk(pc_o == e_pc, {tag, " pc"}, pc_o, e_pc);
    if (mode >= 2) chk({a_o, x_o, cc_o} == {e_a, e_x, e_cc}, {tag, " a/x/cc"},
                       {a_o, x_o, cc_o}, {e_a, e_x, e_cc});
  endtask

  task automatic quiet(input string tag, input int cycles);
    n_log = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (busy) n_log = n_log + 100;
    end
    chk(n_log == 0 && !busy, tag, n_log, 0);
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = (i >= 11'h7F8) ? vec_byte(11'(i)) : 8'h00;
    for (int i = 0; i < 32; i++) sh[i] = 8'h00;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sp_o == 11'h07F && !busy && !done, "R1 reset state", {sp_o, busy, done}, {11'h07F, 2'b00});
    n_exp = 0; exp_vec(3); e_cc = 5'b01000;
    n_log = 0; rst_n = 1;
    wait_done("R1");
    judge("R1 start-up vector", 1);
    chk(cc_o[3] == 1'b1, "R1 mask after start", cc_o, 5'b01000);

    // R5 / R2: masked external and timer pending, swi taken anyway
    cc_in = 5'b01000; pc_in = 11'h3A5; a_in = 8'h11; x_in = 8'h22;
    tmr = 1; ext_n = 0;
    quiet("R5 masked ext/tmr not taken", 4);
    prep_int(2);
    issue(0);
    wait_done("R2 swi");
    judge("R2 swi over ext/tmr (R3 push order)", 2);
    cc_in = 5'b01000;
    quiet("R5 still masked after swi", 3);

    // R2: ext over tmr once mask clears
    pc_in = 11'h456; a_in = 8'h5A; x_in = 8'hC3; cc_in = 5'b10101;
    prep_int(1);
    n_log = 0;
    wait_done("R2 ext");
    judge("R2 ext over tmr, R4 vector", 2);
    cc_in = 5'b01000;
    tmr = 0;
    @(negedge clk);
    cc_in = 5'b00000;
    quiet("R6 held-low line no retrigger", 6);

    // R5 timer
    pc_in = 11'h7FF; a_in = 8'h80; x_in = 8'h01; cc_in = 5'b00010;
    prep_int(0);
    n_log = 0; tmr = 1;
    wait_done("R5 timer");
    cc_in = 5'b01000; tmr = 0;
    judge("R5 timer vector and mask", 2);

    // R7 return from interrupt twice
    prep_rti(); issue(1); wait_done("R7 rti"); judge("R7 rti restore 1", 2);
    prep_rti(); issue(1); wait_done("R7 rti"); judge("R7 rti restore 2", 2);

    // R8 call/return
    pc_in = 11'h2C7;
    prep_jsr(); issue(3); wait_done("R8 jsr"); judge("R8 call push", 0);
    pc_in = 11'h000;
    prep_rts(); issue(2); wait_done("R8 rts"); judge("R8 return pull", 1);

    // R11 command during busy ignored
    pc_in = 11'h135;
    prep_jsr();
    n_log = 0; jsr = 1; @(posedge clk); @(negedge clk);
    jsr = 0; rti = 1; @(negedge clk); rti = 0;
    wait_done("R11 jsr");
    judge("R11 call with stray command", 0);
    quiet("R11 stray command ignored", 5);
    chk(sp_o == stk(bsp), "R11 sp untouched", sp_o, stk(bsp));

    // R10 stack pointer reset
    issue(4);
    bsp = 5'h1F; n_exp = 0;
    wait_done("R10 rsp");
    chk(sp_o == 11'h07F, "R10 sp reset", sp_o, 11'h07F);
    chk(n_log == 0, "R10 no bus access", n_log, 0);

    // R9 wrap: seven entries then seven returns
    for (int k = 0; k < 7; k++) begin
      pc_in = 11'($urandom); a_in = 8'($urandom); x_in = 8'($urandom); cc_in = 5'($urandom);
      prep_int(2); issue(0); wait_done("R9 push"); judge("R9 wrap entry", 2);
    end
    for (int k = 0; k < 7; k++) begin
      prep_rti(); issue(1); wait_done("R9 pull"); judge("R9 wrap return", 2);
    end

    // random mix
    cc_in = 5'b01000; ext_n = 1;
    for (int k = 0; k < 60; k++) begin
      int r;
      r = $urandom_range(0, 3);
      pc_in = 11'($urandom); a_in = 8'($urandom); x_in = 8'($urandom); cc_in = 5'($urandom);
      case (r)
        0: begin prep_jsr(); issue(3); wait_done("R8 rnd"); judge("R8 random call", 0); end
        1: begin prep_rts(); issue(2); wait_done("R8 rnd"); judge("R8 random return", 1); end
        2: begin prep_int(2); issue(0); wait_done("R3 rnd"); judge("R3 random entry", 2); end
        default: begin prep_rti(); issue(1); wait_done("R7 rnd"); judge("R7 random rti", 2); end
      endcase
    end

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog R11 actual=%h expected=%h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule